// File: doc/BRIEF.md
# Ping-Pong Buffer Swap Controller

This block coordinates two data buffers shared between a processor-side agent and a DMA-side agent. At any moment one agent fills one buffer while the other agent drains the second buffer. The controller tells each agent which buffer it owns. It latches a one-cycle completion pulse from each agent. It exchanges the two buffers only after both agents have finished with their current buffer. The agent that finishes first is held, and its waiting interval appears on a per-side output.

A configuration input chooses the direction. When it is low, the processor side fills and the DMA side drains. When it is high, the roles are reversed. After reset the filling agent owns buffer 0. The draining agent owns buffer 1, which counts as empty and already drained, so the first exchange needs only the filler's completion. Each exchange raises a one-cycle start pulse to both agents and advances a wrapping exchange counter.

Top module: `pingpong_swap_ctrl`

## Requirements
- R1: After reset the filler's buffer select is 0 and the drainer's select is 1. The counter is 0 and both start outputs are low. The drainer's wait output is high and the filler's wait output is low.
- R2: A done pulse from a side raises that side's wait output on the following cycle. The wait output stays high until the next exchange.
- R3: An exchange happens on the clock edge after both wait outputs are high. On that edge both buffer selects invert, both wait outputs clear and the counter increments by one.
- R4: Each exchange drives cpu_start and dma_start high for exactly one cycle. That cycle is the first one in which the new selects are shown.
- R5: While only one side is waiting, the buffer selects and the counter do not change.
- R6: The two buffer selects always differ.
- R7: With dma_fills = 0 the processor side is the filler. With dma_fills = 1 the DMA side is the filler. A done pulse from the drainer at reset, when it is already waiting, causes no exchange.
- R8: A done pulse from a side that is already waiting has no effect. This includes a pulse in the cycle of an exchange: it is not counted toward the next exchange.
- R9: The stall output is high exactly when at least one wait output is high.
- R10: The counter is CNT_W bits wide and wraps to 0 after its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_fills | input | 1 | Direction: 1 = DMA side fills, 0 = processor side fills |
| cpu_done | input | 1 | One-cycle completion pulse from the processor side |
| dma_done | input | 1 | One-cycle completion pulse from the DMA side |
| cpu_buf | output | 1 | Buffer owned by the processor side |
| dma_buf | output | 1 | Buffer owned by the DMA side |
| cpu_start | output | 1 | One-cycle start pulse to the processor side after an exchange |
| dma_start | output | 1 | One-cycle start pulse to the DMA side after an exchange |
| cpu_wait | output | 1 | Processor side has finished and is held |
| dma_wait | output | 1 | DMA side has finished and is held |
| stall | output | 1 | At least one side is held |
| swap_cnt | output | CNT_W | Number of exchanges, wrapping |

## Verification
The completion pulses are applied in several patterns: filler first, drainer first, both in the same cycle, and repeated pulses from a side that is already held. Filler-first and drainer-first show that the exchange waits for the slower side regardless of order. Same-cycle pulses show the shortest path through an exchange. A pulse that lands on the exchange edge separates a design that drops it from one that carries it into the next round. Running with both direction settings confirms which physical side is bound to the filling role. A long run of back-to-back exchanges checks that the counter wraps.

// File: rtl/pps_pkg.sv
package pps_pkg;
   typedef enum logic {BUF_ZERO = 1'b0, BUF_ONE = 1'b1} buf_id_t;
   localparam int unsigned NUM_ROLES  = 2;
   localparam int unsigned ROLE_FILL  = 0;
   localparam int unsigned ROLE_DRAIN = 1;
endpackage

// File: rtl/pps_side_flag.sv
module pps_side_flag #(
   parameter bit INIT_SET = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic done,
   input  logic swap,
   output logic flag
);
   // an exchange wins over a completion pulse in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n)    flag <= INIT_SET;
      else if (swap) flag <= 1'b0;
      else if (done) flag <= 1'b1;
   end
endmodule

// File: rtl/pps_role_map.sv
module pps_role_map
   import pps_pkg::*;
(
   input  logic    dma_fills,
   input  logic    cpu_done,
   input  logic    dma_done,
   input  logic    fill_flag,
   input  logic    drain_flag,
   input  buf_id_t fill_sel,
   output logic    fill_done,
   output logic    drain_done,
   output logic    cpu_wait,
   output logic    dma_wait,
   output logic    cpu_buf,
   output logic    dma_buf
);
   logic drain_sel;

   always_comb begin
      drain_sel = ~fill_sel;
      if (dma_fills) begin
         fill_done  = dma_done;
         drain_done = cpu_done;
         dma_wait   = fill_flag;
         cpu_wait   = drain_flag;
         dma_buf    = fill_sel;
         cpu_buf    = drain_sel;
      end else begin
         fill_done  = cpu_done;
         drain_done = dma_done;
         cpu_wait   = fill_flag;
         dma_wait   = drain_flag;
         cpu_buf    = fill_sel;
         dma_buf    = drain_sel;
      end
   end
endmodule

// File: rtl/pps_swap_seq.sv
module pps_swap_seq
   import pps_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fill_flag,
   input  logic             drain_flag,
   output logic             swap,
   output buf_id_t          fill_sel,
   output logic             start,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   assign swap = fill_flag & drain_flag;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill_sel <= BUF_ZERO;
         start    <= 1'b0;
         cnt      <= '0;
      end else begin
         start <= swap;
         if (swap) begin
            fill_sel <= (fill_sel == BUF_ZERO) ? BUF_ONE : BUF_ZERO;
            cnt      <= cnt + CNT_ONE;
         end
      end
   end
endmodule

// File: rtl/pingpong_swap_ctrl.sv
module pingpong_swap_ctrl
   import pps_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dma_fills,
   input  logic             cpu_done,
   input  logic             dma_done,
   output logic             cpu_buf,
   output logic             dma_buf,
   output logic             cpu_start,
   output logic             dma_start,
   output logic             cpu_wait,
   output logic             dma_wait,
   output logic             stall,
   output logic [CNT_W-1:0] swap_cnt
);
   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_width
         $error("pingpong_swap_ctrl: CNT_W must lie in 1..32");
      end
   endgenerate

   logic [NUM_ROLES-1:0] role_done;
   logic [NUM_ROLES-1:0] role_flag;
   logic                 swap;
   logic                 start;
   buf_id_t              fill_sel;

   // one completion latch per role; the drain role starts out as already drained
   generate
      for (genvar r = 0; r < NUM_ROLES; r++) begin : g_role
         pps_side_flag #(
            .INIT_SET (r == ROLE_DRAIN)
         ) u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .done  (role_done[r]),
            .swap  (swap),
            .flag  (role_flag[r])
         );
      end
   endgenerate

   pps_role_map u_map (
      .dma_fills  (dma_fills),
      .cpu_done   (cpu_done),
      .dma_done   (dma_done),
      .fill_flag  (role_flag[ROLE_FILL]),
      .drain_flag (role_flag[ROLE_DRAIN]),
      .fill_sel   (fill_sel),
      .fill_done  (role_done[ROLE_FILL]),
      .drain_done (role_done[ROLE_DRAIN]),
      .cpu_wait   (cpu_wait),
      .dma_wait   (dma_wait),
      .cpu_buf    (cpu_buf),
      .dma_buf    (dma_buf)
   );

   pps_swap_seq #(
      .CNT_W (CNT_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .fill_flag  (role_flag[ROLE_FILL]),
      .drain_flag (role_flag[ROLE_DRAIN]),
      .swap       (swap),
      .fill_sel   (fill_sel),
      .start      (start),
      .cnt        (swap_cnt)
   );

   assign cpu_start = start;
   assign dma_start = start;
   assign stall     = |role_flag;
endmodule

// File: rtl/pps_chk.sv
module pps_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dma_fills,
   input logic             cpu_done,
   input logic             dma_done,
   input logic             cpu_buf,
   input logic             dma_buf,
   input logic             cpu_start,
   input logic             dma_start,
   input logic             cpu_wait,
   input logic             dma_wait,
   input logic             stall,
   input logic [CNT_W-1:0] swap_cnt
);
   // R4
   start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_start |=> !cpu_start);

   // R3
   swap_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_start && $stable(dma_fills)) |-> (cpu_buf != $past(cpu_buf)));

   // R3
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_start |-> (swap_cnt == CNT_W'($past(swap_cnt) + 1'b1)));

   // R3
   swap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_start |-> (!cpu_wait && !dma_wait));

   // R5
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_start && $stable(dma_fills)) |-> ($stable(cpu_buf) && $stable(swap_cnt)));

   // R2
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wait && !dma_wait && $stable(dma_fills)) |=> (cpu_wait || cpu_start));

   // R4
   start_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_start == dma_start);
endmodule

bind pingpong_swap_ctrl pps_chk #(.CNT_W(CNT_W)) u_pps_chk (.*);

// File: tb/test_pingpong_swap_ctrl.sv
module test_pingpong_swap_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          dma_fills = 1'b0;
   logic          cpu_done = 1'b0;
   logic          dma_done = 1'b0;
   logic          cpu_buf, dma_buf, cpu_start, dma_start, cpu_wait, dma_wait, stall;
   logic [CW-1:0] swap_cnt;

   int total = 0;
   int bad = 0;
   bit ended = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pingpong_swap_ctrl #(.CNT_W(CW)) i_pingpong_swap_ctrl (
      .clk(clk), .rst_n(rst_n), .dma_fills(dma_fills),
      .cpu_done(cpu_done), .dma_done(dma_done),
      .cpu_buf(cpu_buf), .dma_buf(dma_buf),
      .cpu_start(cpu_start), .dma_start(dma_start),
      .cpu_wait(cpu_wait), .dma_wait(dma_wait),
      .stall(stall), .swap_cnt(swap_cnt)
   );

   // fields: cd dd | cpu_buf dma_buf cpu_wait dma_wait start | cnt[3:0]
   localparam int NV = 10;
   localparam logic [10:0] VEC [NV] = '{
      {2'b10, 5'b01110, 4'd0},  // R2 filler done, drainer waiting from reset
      {2'b00, 5'b10001, 4'd1},  // R3 R4 exchange
      {2'b01, 5'b10010, 4'd1},  // R2 drainer finishes first
      {2'b00, 5'b10010, 4'd1},  // R5 one side held, no change
      {2'b01, 5'b10010, 4'd1},  // R8 repeat pulse while held
      {2'b10, 5'b10110, 4'd1},  // R2 filler done
      {2'b00, 5'b01001, 4'd2},  // R3 exchange back
      {2'b11, 5'b01110, 4'd2},  // R2 both in same cycle
      {2'b11, 5'b10001, 4'd3},  // R8 pulses on the exchange edge
      {2'b00, 5'b10000, 4'd3}   // R8 those pulses were dropped
   };

   task automatic check(input string req, input int act, input int exp_v);
      total++;
      if (act != exp_v) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   task automatic do_reset(input logic dir);
      @(negedge clk);
      rst_n = 1'b0; cpu_done = 1'b0; dma_done = 1'b0; dma_fills = dir;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   task automatic step(input logic cd, input logic dd);
      @(negedge clk);
      cpu_done = cd; dma_done = dd;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      finish_run();
   end

   initial begin
      // R1 reset state, processor side fills
      do_reset(1'b0);
      check("R1 cpu_buf", cpu_buf, 0);
      check("R1 dma_buf", dma_buf, 1);
      check("R1 cnt", swap_cnt, 0);
      check("R1 start", cpu_start, 0);
      check("R1 dma_wait", dma_wait, 1);
      check("R1 cpu_wait", cpu_wait, 0);
      check("R9 stall at reset", stall, 1);

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][10], VEC[i][9]);
         check("R3 cpu_buf", cpu_buf, VEC[i][8]);
         check("R6 dma_buf", dma_buf, VEC[i][7]);
         check("R2 cpu_wait", cpu_wait, VEC[i][6]);
         check("R2 dma_wait", dma_wait, VEC[i][5]);
         check("R4 cpu_start", cpu_start, VEC[i][4]);
         check("R4 dma_start", dma_start, VEC[i][4]);
         check("R9 stall", stall, VEC[i][6] | VEC[i][5]);
         check("R3 cnt", swap_cnt, VEC[i][3:0]);
      end
      step(1'b0, 1'b0);
      check("R4 start one cycle", cpu_start, 0);

      // R7 DMA side fills
      do_reset(1'b1);
      check("R7 dma_buf fill", dma_buf, 0);
      check("R7 cpu_buf drain", cpu_buf, 1);
      check("R7 cpu_wait drainer", cpu_wait, 1);
      check("R7 dma_wait", dma_wait, 0);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      check("R7 drainer pulse no exchange", swap_cnt, 0);
      check("R7 dma_buf held", dma_buf, 0);
      step(1'b0, 1'b1);
      check("R7 dma_wait set", dma_wait, 1);
      step(1'b0, 1'b0);
      check("R7 exchange dma_buf", dma_buf, 1);
      check("R7 exchange cpu_buf", cpu_buf, 0);
      check("R7 start", dma_start, 1);
      check("R7 cnt", swap_cnt, 1);

      // R10 counter wrap
      do_reset(1'b0);
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      for (int n = 2; n <= 16; n++) begin
         step(1'b1, 1'b1);
         step(1'b0, 1'b0);
         if (n == 15) check("R10 count max", swap_cnt, 15);
      end
      check("R10 wrap to zero", swap_cnt, 0);
      check("R10 sel after 16", cpu_buf, 0);

      finish_run();
   end
endmodule